// File: doc/BRIEF.md
# Byte-Accessed Capture Timer

This block is a free-running 16-bit up-counter that software reaches through an 8-bit register bus. Two input-capture channels watch external event lines. On a rising edge they copy the current count into a 16-bit capture register of their own and raise a capture flag. When the count rolls over from its top value to zero, an overflow flag is raised. All channels share the one counter, so a single overflow event serves both.

Every 16-bit quantity is split across two byte addresses. One temporary byte register, shared by all of them, makes each two-byte access atomic. Reading a low byte latches the matching high byte. Writing a high byte only parks it, and the following low-byte write commits all 16 counter bits in one cycle. Flags are sticky and are cleared by writing ones. Each flag is ANDed with an enable bit to give a registered interrupt request. Software can poll the flags with every enable off.

Address map (4-bit address, default parameters):

| Addr | Read | Write |
|---|---|---|
| 0 | count low byte | count low byte, commits count |
| 1 | shared temp | shared temp |
| 2 / 3 | capture 0 low byte / shared temp | ignored / ignored |
| 4 / 5 | capture 1 low byte / shared temp | ignored / ignored |
| 6 | flags | write 1 to clear |
| 7 | enables | enables |

Top module: `cap_timer_top`

## Requirements
- R1: After reset the count, the captures, the flags, the enables, `rdata_o` and `irq_o` are zero. The count rises by one on each clock with `cnt_en_i` high and holds with it low.
- R2: A read strobe returns the addressed byte on `rdata_o` from the following cycle. A read of address 0 returns the count's low byte and copies the count's high byte into the shared temp. A read of address 1 returns the shared temp.
- R3: A write to address 1 loads only the shared temp and leaves the count unchanged. A write to address 0 sets the count to {temp, data} in one cycle, and this takes priority over counting.
- R4: When the count passes from 0xFFFF to 0x0000, flag bit 0 (overflow) is set.
- R5: Each capture input passes through a two-flop synchronizer. A rising edge copies the current count into that channel's capture register and sets flag bit 1+n in the same cycle. A held-high level does not capture again. Channels do not affect each other.
- R6: A read of capture n's low byte (address 2+2n) copies that capture's high byte into the shared temp. Any high-byte address (1, 3, 5) reads the shared temp, whichever low byte filled it last.
- R7: Flags (address 6) stay set until a 1 is written to their bit position. Writing 0 and writing the count leave them unchanged.
- R8: If a flag's set event and its clear write fall in the same cycle, the flag ends set.
- R9: Flags are set whatever the enables at address 7 hold.
- R10: `irq_o[i]` equals flag bit i AND enable bit i, registered, and is active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Count enable |
| cap_i | input | 2 | Asynchronous capture event lines, one per channel |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 3 | Interrupt requests: bit 0 overflow, bit 1+n capture n |

## Verification
The assertions assume that a read and a write strobe never arrive in the same cycle. They also assume that each capture line stays at a level for at least three clocks, so that the synchronizer sees every edge once. The stimulus drives bus strobes one at a time on falling edges, each for a single cycle. It holds every capture pulse high for four or more cycles. It keeps the count still, except during stated tick bursts, so that the values captured and read back can be known ahead of time.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_CAP   = 2;
  localparam int unsigned BUS_AW  = 4;

  // low byte of capture channel n; high byte is the next address
  function automatic int unsigned cap_lo_addr(int unsigned n);
    return 2 + 2 * n;
  endfunction
endpackage

// File: rtl/cap_timer_counter.sv
module cap_timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i && !load_i && (&cnt_q);

  p_count_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  p_count_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_i |=> $stable(cnt_q));
  p_load_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/cap_timer_capture.sv
module cap_timer_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             hit_o
);
  logic sync1_q, sync2_q, prev_q;
  logic [CNT_W-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= evt_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign hit_o = sync2_q && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_q <= '0;
    else if (hit_o) cap_q <= cnt_i;
  end

  assign cap_o = cap_q;

  p_capture_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cap_q == $past(cnt_i));
  p_capture_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> $stable(cap_q));
  p_single_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
endmodule

// File: rtl/cap_timer_regs.sv
module cap_timer_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_CAP = 2,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CNT_W  = 2 * DATA_W,
  localparam int unsigned FLAG_W = NUM_CAP + 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic                            wr_en_i,
  input  logic                            rd_en_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [CNT_W-1:0]                cnt_i,
  input  logic                            wrap_i,
  input  logic [NUM_CAP-1:0][CNT_W-1:0]   cap_i,
  input  logic [NUM_CAP-1:0]              hit_i,
  output logic                            cnt_load_o,
  output logic [CNT_W-1:0]                cnt_load_val_o,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [FLAG_W-1:0]               irq_o
);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FLAG   = ADDR_W'(2 + 2 * NUM_CAP);
  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(3 + 2 * NUM_CAP);

  logic [DATA_W-1:0] temp_q, temp_d;
  logic [FLAG_W-1:0] flags_q, en_q, set_vec, clr_vec;
  logic [DATA_W-1:0] rd_mux;

  // shared high-byte latch
  always_comb begin
    temp_d = temp_q;
    if (wr_en_i && addr_i == A_CNT_HI) temp_d = wdata_i;
    if (rd_en_i && addr_i == A_CNT_LO) temp_d = cnt_i[CNT_W-1:DATA_W];
    for (int n = 0; n < NUM_CAP; n++) begin
      if (rd_en_i && addr_i == ADDR_W'(2 + 2 * n)) temp_d = cap_i[n][CNT_W-1:DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) temp_q <= '0;
    else         temp_q <= temp_d;
  end

  assign cnt_load_o     = wr_en_i && addr_i == A_CNT_LO;
  assign cnt_load_val_o = {temp_q, wdata_i};

  // sticky flags, write-one-to-clear, set dominates
  assign set_vec = {hit_i, wrap_i};
  assign clr_vec = (wr_en_i && addr_i == A_FLAG) ? wdata_i[FLAG_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
      irq_o   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (wr_en_i && addr_i == A_EN) en_q <= wdata_i[FLAG_W-1:0];
      irq_o   <= flags_q & en_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_CNT_LO)      rd_mux = cnt_i[DATA_W-1:0];
    else if (addr_i == A_CNT_HI) rd_mux = temp_q;
    else if (addr_i == A_FLAG)   rd_mux = DATA_W'(flags_q);
    else if (addr_i == A_EN)     rd_mux = DATA_W'(en_q);
    for (int n = 0; n < NUM_CAP; n++) begin
      if (addr_i == ADDR_W'(2 + 2 * n)) rd_mux = cap_i[n][DATA_W-1:0];
      if (addr_i == ADDR_W'(3 + 2 * n)) rd_mux = temp_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  p_lo_read_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == A_CNT_LO |=> temp_q == $past(cnt_i[CNT_W-1:DATA_W]));
  p_hi_write_park_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == A_CNT_HI |=> temp_q == $past(wdata_i));
  p_wrap_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flags_q[0]);
  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q[0] && !clr_vec[0] |=> flags_q[0]);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i && clr_vec[0] |=> flags_q[0]);
  p_irq_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == '0 |=> irq_o == '0);

  for (genvar n = 0; n < NUM_CAP; n++) begin : g_cap_chk
    p_cap_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[n] |=> flags_q[n+1]);
    p_cap_lo_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i && addr_i == ADDR_W'(2 + 2 * n) |=> temp_q == $past(cap_i[n][CNT_W-1:DATA_W]));
  end
endmodule

// File: rtl/cap_timer_top.sv
module cap_timer_top
  import cap_timer_pkg::*;
#(
  parameter int unsigned DATA_W  = BYTE_W,
  parameter int unsigned NUM_CAP = N_CAP,
  parameter int unsigned ADDR_W  = BUS_AW,
  localparam int unsigned CNT_W  = 2 * DATA_W,
  localparam int unsigned FLAG_W = NUM_CAP + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_i,
  input  logic [NUM_CAP-1:0] cap_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [FLAG_W-1:0]  irq_o
);
  logic [CNT_W-1:0]              cnt, load_val;
  logic                          load, wrap;
  logic [NUM_CAP-1:0][CNT_W-1:0] cap_val;
  logic [NUM_CAP-1:0]            hit;

  cap_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(cnt_en_i), .load_i(load), .load_val_i(load_val),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  for (genvar n = 0; n < NUM_CAP; n++) begin : g_cap
    cap_timer_capture #(.CNT_W(CNT_W)) u_cap (
      .clk_i, .rst_ni, .evt_i(cap_i[n]), .cnt_i(cnt),
      .cap_o(cap_val[n]), .hit_o(hit[n])
    );
  end

  cap_timer_regs #(.DATA_W(DATA_W), .NUM_CAP(NUM_CAP), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i,
    .cnt_i(cnt), .wrap_i(wrap), .cap_i(cap_val), .hit_i(hit),
    .cnt_load_o(load), .cnt_load_val_o(load_val), .rdata_o, .irq_o
  );
endmodule

// File: tb/tb_cap_timer_top.sv
module tb_cap_timer_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
  localparam int NVEC = 28;
  // {op, addr, data, expected, requirement number}
  localparam logic [25:0] VEC [NVEC] = '{
    {OP_RD, 4'd6, 8'h00, 8'h00, 4'd7},  // R7 flags clear after reset
    {OP_RD, 4'd0, 8'h00, 8'h00, 4'd1},  // R1 count zero after reset
    {OP_WR, 4'd1, 8'h12, 8'h00, 4'd0},
    {OP_WR, 4'd0, 8'h34, 8'h00, 4'd0},
    {OP_RD, 4'd0, 8'h00, 8'h34, 4'd3},  // R3 low write committed
    {OP_RD, 4'd1, 8'h00, 8'h12, 4'd2},  // R2 high from latch
    {OP_WR, 4'd1, 8'hAB, 8'h00, 4'd0},
    {OP_RD, 4'd1, 8'h00, 8'hAB, 4'd3},  // R3 temp only
    {OP_RD, 4'd0, 8'h00, 8'h34, 4'd3},
    {OP_RD, 4'd1, 8'h00, 8'h12, 4'd3},  // R3 count high untouched
    {OP_TK, 4'd0, 8'd5,  8'h00, 4'd0},
    {OP_RD, 4'd0, 8'h00, 8'h39, 4'd1},  // R1 five ticks
    {OP_RD, 4'd1, 8'h00, 8'h12, 4'd1},
    {OP_WR, 4'd1, 8'hFF, 8'h00, 4'd0},
    {OP_WR, 4'd0, 8'hFE, 8'h00, 4'd0},
    {OP_RD, 4'd6, 8'h00, 8'h00, 4'd4},  // R4 no flag before wrap
    {OP_TK, 4'd0, 8'd2,  8'h00, 4'd0},
    {OP_RD, 4'd6, 8'h00, 8'h01, 4'd4},  // R4 wrap sets bit 0
    {OP_RD, 4'd0, 8'h00, 8'h00, 4'd4},
    {OP_RD, 4'd1, 8'h00, 8'h00, 4'd4},
    {OP_WR, 4'd6, 8'h00, 8'h00, 4'd0},
    {OP_RD, 4'd6, 8'h00, 8'h01, 4'd7},  // R7 zero write keeps flag
    {OP_WR, 4'd1, 8'h55, 8'h00, 4'd0},
    {OP_WR, 4'd0, 8'h00, 8'h00, 4'd0},
    {OP_RD, 4'd6, 8'h00, 8'h01, 4'd7},  // R7 count write keeps flag
    {OP_RD, 4'd7, 8'h00, 8'h00, 4'd9},  // R9 flag set with enables off
    {OP_WR, 4'd6, 8'h01, 8'h00, 4'd0},
    {OP_RD, 4'd6, 8'h00, 8'h00, 4'd7}   // R7 one clears
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0, cnt_en_i = 1'b0;
  logic [1:0] cap_i = '0;
  logic [3:0] addr_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] rv;

  cap_timer_top dut (
    .clk_i, .rst_ni, .cnt_en_i, .cap_i, .addr_i, .wr_en_i, .rd_en_i,
    .wdata_i, .rdata_o, .irq_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i); rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic tick(int n);
    @(negedge clk_i); cnt_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    cnt_en_i = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [7:0] exp);
    logic [7:0] d;
    bus_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse_wait(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset rdata", rdata_o, 8'h00);
    chk("R1 reset irq", {5'd0, irq_o}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][25:24])
        OP_WR: bus_wr(VEC[i][23:20], VEC[i][19:12]);
        OP_TK: tick(int'(VEC[i][19:12]));
        default: begin
          bus_rd(VEC[i][23:20], rv);
          chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), rv, VEC[i][11:4]);
        end
      endcase
    end

    // R5 capture on channel 0, count held at 0x4321
    bus_wr(4'd1, 8'h43); bus_wr(4'd0, 8'h21);
    @(negedge clk_i); cap_i[0] = 1'b1;
    pulse_wait(4); cap_i[0] = 1'b0;
    pulse_wait(3);
    rd_chk("R5 cap0 flag", 4'd6, 8'h02);
    rd_chk("R6 cap0 low", 4'd2, 8'h21);
    rd_chk("R6 cap0 high via temp", 4'd3, 8'h43);
    rd_chk("R5 cap1 untouched", 4'd4, 8'h00);

    // channel 1 at 0x9876, held high afterwards
    bus_wr(4'd1, 8'h98); bus_wr(4'd0, 8'h76);
    @(negedge clk_i); cap_i[1] = 1'b1;
    pulse_wait(4);
    rd_chk("R5 both flags", 4'd6, 8'h06);
    rd_chk("R5 cap1 low", 4'd4, 8'h76);
    bus_rd(4'd2, rv);
    rd_chk("R6 shared temp from cap0", 4'd5, 8'h43);
    bus_rd(4'd4, rv);
    rd_chk("R6 shared temp from cap1", 4'd3, 8'h98);
    bus_wr(4'd1, 8'h11); bus_wr(4'd0, 8'h11);
    pulse_wait(4);
    rd_chk("R5 level no recapture", 4'd4, 8'h76);
    cap_i[1] = 1'b0;
    pulse_wait(3);

    // R10 interrupt gating
    chk("R10 irq masked", {5'd0, irq_o}, 8'h00);
    bus_wr(4'd7, 8'h02);
    @(negedge clk_i);
    chk("R10 irq cap0 only", {5'd0, irq_o}, 8'h02);
    bus_wr(4'd6, 8'h02);
    @(negedge clk_i);
    chk("R10 irq drops after clear", {5'd0, irq_o}, 8'h00);
    rd_chk("R7 cap0 flag cleared", 4'd6, 8'h04);

    // R8 set and clear in the same cycle
    bus_wr(4'd1, 8'hFF); bus_wr(4'd0, 8'hFE);
    tick(2);
    rd_chk("R4 flag set again", 4'd6, 8'h05);
    bus_wr(4'd1, 8'hFF); bus_wr(4'd0, 8'hFF);
    @(negedge clk_i); addr_i = 4'd6; wdata_i = 8'h01; wr_en_i = 1'b1; cnt_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0; cnt_en_i = 1'b0;
    rd_chk("R8 set beats clear", 4'd6, 8'h05);
    bus_wr(4'd6, 8'h01);
    rd_chk("R8 plain clear works", 4'd6, 8'h04);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule